// File: doc/BRIEF.md
# Saturating Wiper Position Counter

This block keeps the volatile tap position of a digitally controlled resistor divider and drives the switch-enable vector for its taps. The position is a small unsigned value. Its one-hot decode turns on exactly one tap switch. Index 0 is the low-end terminal and the top index is the high-end terminal. The analog array itself lives outside the block.

Four sources can load the position. A recall value (the contents of stored register zero) is loaded while reset is held. A parallel copy comes from whichever stored register the command decoder selected. A direct write value comes from the serial command path. In step mode, the counter watches the raw serial clock and serial data lines itself. Each clock pulse moves the wiper by one tap: toward the high end when data is high, toward the low end when data is low. Step mode has no fixed length and ends only when chip select is released.

The serial clock, serial data and active-low select lines are asynchronous to `clk` and pass through a synchronizer. Recall has the highest priority, then copy, then write, then a step.

Top module: `wiper_pos_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `pos` takes `recall_val`, and `tap_sel` becomes the one-hot code of that value. Step mode is cleared.
- R2: At every cycle after reset, `tap_sel` has exactly one bit set, at bit index `pos`. Bit 0 is the low-end tap and bit 63 is the high-end tap.
- R3: `copy_en` high at an edge loads `copy_val` into `pos` at that edge.
- R4: `wr_en` high at an edge, with `copy_en` low, loads `wr_val` into `pos` at that edge.
- R5: When `copy_en` and `wr_en` are both high, `copy_val` is loaded and `wr_val` is discarded.
- R6: A copy or write that lands in the same cycle as a detected step pulse takes the place of that step. The step is dropped and is not applied later.
- R7: In step mode, each low-to-high transition of `sclk` changes `pos` by exactly one, on the third `clk` edge after the transition (two synchronizer stages plus the edge detector). The move is +1 if `sdat` is 1 and −1 if `sdat` is 0. A pulse held high for many cycles still counts once.
- R8: A step up at 63 leaves `pos` at 63, and a step down at 0 leaves `pos` at 0. There is no wrap.
- R9: Step mode starts with a one-cycle `step_go` pulse while `sel_n` is low. It stays active for any number of pulses until the synchronized `sel_n` is seen high. After that, `sclk` pulses leave `pos` unchanged.
- R10: `sclk` pulses while step mode is inactive leave `pos` and `tap_sel` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset; performs the recall load |
| recall_val | input | 6 | Value of stored register zero, loaded during reset |
| copy_en | input | 1 | Parallel copy strobe |
| copy_val | input | 6 | Value of the selected stored register |
| wr_en | input | 1 | Direct write strobe |
| wr_val | input | 6 | Direct write value |
| step_go | input | 1 | One-cycle pulse that enters step mode |
| sel_n | input | 1 | Asynchronous active-low chip select; high ends step mode |
| sclk | input | 1 | Asynchronous serial clock; its pulses are steps |
| sdat | input | 1 | Asynchronous serial data; sets the step direction |
| pos | output | 6 | Registered wiper position |
| tap_sel | output | 64 | Registered one-hot tap enable vector |

## Verification
All 64 positions are driven twice. The first sweep uses direct writes alone, which shows that the decoder places the enable bit at the right index for every value. The second sweep asserts copy and write together with complementary values, which tells copy-over-write priority apart from a merge or the reverse order. Step patterns use runs of up-pulses into the top rail and down-pulses from 63 through 0 and below, which separates saturation from wrap-around. One long-held clock pulse tells edge counting apart from level counting. Further patterns cover steps that collide with a copy or a write, pulses sent after select is released, pulses sent before step mode is entered, and a second reset with a different recall value.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  typedef enum logic [2:0] {
    SRC_HOLD   = 3'd0,
    SRC_RECALL = 3'd1,
    SRC_COPY   = 3'd2,
    SRC_WRITE  = 3'd3,
    SRC_STEP   = 3'd4
  } load_src_e;

endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_in;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign d_out = stg_q[STAGES-1];

endmodule

// File: rtl/wiper_step_detect.sv
module wiper_step_detect (
  input  logic clk,
  input  logic rst,
  input  logic sclk_s,
  input  logic sdat_s,
  input  logic sel_hi_s,
  input  logic step_go,
  output logic step_active,
  output logic step_fire,
  output logic step_up
);

  logic sclk_prev_q;
  logic active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev_q <= 1'b0;
      active_q    <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_s;
      if (sel_hi_s)
        active_q <= 1'b0;
      else if (step_go)
        active_q <= 1'b1;
    end
  end

  assign step_active = active_q;
  assign step_fire   = active_q & sclk_s & ~sclk_prev_q;
  assign step_up     = sdat_s;

endmodule

// File: rtl/wiper_core.sv
module wiper_core
  import wiper_pkg::*;
#(
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] recall_val,
  input  logic             copy_en,
  input  logic [POS_W-1:0] copy_val,
  input  logic             wr_en,
  input  logic [POS_W-1:0] wr_val,
  input  logic             step_fire,
  input  logic             step_up,
  output logic [POS_W-1:0] pos_q,
  output logic [POS_W-1:0] pos_nxt
);

  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam logic [POS_W-1:0] POS_MIN = '0;

  load_src_e        src;
  logic [POS_W-1:0] stepped;

  always_comb begin
    if (rst)            src = SRC_RECALL;
    else if (copy_en)   src = SRC_COPY;
    else if (wr_en)     src = SRC_WRITE;
    else if (step_fire) src = SRC_STEP;
    else                src = SRC_HOLD;
  end

  always_comb begin
    if (step_up)
      stepped = (pos_q == POS_MAX) ? pos_q : pos_q + 1'b1;
    else
      stepped = (pos_q == POS_MIN) ? pos_q : pos_q - 1'b1;
  end

  always_comb begin
    unique case (src)
      SRC_RECALL: pos_nxt = recall_val;
      SRC_COPY:   pos_nxt = copy_val;
      SRC_WRITE:  pos_nxt = wr_val;
      SRC_STEP:   pos_nxt = stepped;
      default:    pos_nxt = pos_q;
    endcase
  end

  always_ff @(posedge clk) begin
    pos_q <= pos_nxt;
  end

endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
  parameter int POS_W = 6,
  localparam int TAPS = 1 << POS_W
) (
  input  logic             clk,
  input  logic [POS_W-1:0] pos_nxt,
  output logic [TAPS-1:0]  tap_q
);

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    always_ff @(posedge clk) begin
      tap_q[i] <= (pos_nxt == POS_W'(i));
    end
  end

endmodule

// File: rtl/wiper_pos_ctrl.sv
module wiper_pos_ctrl #(
  parameter int POS_W       = 6,
  parameter int SYNC_STAGES = 2,
  localparam int TAPS       = 1 << POS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] recall_val,
  input  logic             copy_en,
  input  logic [POS_W-1:0] copy_val,
  input  logic             wr_en,
  input  logic [POS_W-1:0] wr_val,
  input  logic             step_go,
  input  logic             sel_n,
  input  logic             sclk,
  input  logic             sdat,
  output logic [POS_W-1:0] pos,
  output logic [TAPS-1:0]  tap_sel
);

  logic [2:0]       line_s;
  logic             step_active;
  logic             step_fire;
  logic             step_up;
  logic [POS_W-1:0] pos_nxt;

  // bit 2: select (idles high), bit 1: serial clock, bit 0: serial data
  wiper_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) sync_i (
    .clk  (clk),
    .rst  (rst),
    .d_in ({sel_n, sclk, sdat}),
    .d_out(line_s)
  );

  wiper_step_detect step_i (
    .clk        (clk),
    .rst        (rst),
    .sclk_s     (line_s[1]),
    .sdat_s     (line_s[0]),
    .sel_hi_s   (line_s[2]),
    .step_go    (step_go),
    .step_active(step_active),
    .step_fire  (step_fire),
    .step_up    (step_up)
  );

  wiper_core #(.POS_W(POS_W)) core_i (
    .clk       (clk),
    .rst       (rst),
    .recall_val(recall_val),
    .copy_en   (copy_en),
    .copy_val  (copy_val),
    .wr_en     (wr_en),
    .wr_val    (wr_val),
    .step_fire (step_fire),
    .step_up   (step_up),
    .pos_q     (pos),
    .pos_nxt   (pos_nxt)
  );

  wiper_tap_decode #(.POS_W(POS_W)) dec_i (
    .clk    (clk),
    .pos_nxt(pos_nxt),
    .tap_q  (tap_sel)
  );

endmodule

// File: rtl/wiper_pos_chk.sv
module wiper_pos_chk #(
  parameter int POS_W = 6,
  localparam int TAPS = 1 << POS_W
) (
  input logic             clk,
  input logic             rst,
  input logic [POS_W-1:0] recall_val,
  input logic             copy_en,
  input logic [POS_W-1:0] copy_val,
  input logic             wr_en,
  input logic [POS_W-1:0] wr_val,
  input logic             step_active,
  input logic [POS_W-1:0] pos,
  input logic [TAPS-1:0]  tap_sel
);

  AST_RECALL_LOAD: assert property (@(posedge clk) rst |=> pos == $past(recall_val)); // R1

  AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(tap_sel) == 1); // R2

  AST_TAP_AT_POS: assert property (@(posedge clk) disable iff (rst)
    tap_sel[pos] == 1'b1); // R2

  AST_COPY_LOAD: assert property (@(posedge clk) disable iff (rst)
    copy_en |=> pos == $past(copy_val)); // R3

  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !copy_en) |=> pos == $past(wr_val)); // R4

  AST_STEP_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (!copy_en && !wr_en) |=>
      (pos == $past(pos)) ||
      ({1'b0, pos} == {1'b0, $past(pos)} + 1'b1) ||
      ({1'b0, pos} + 1'b1 == {1'b0, $past(pos)})); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!copy_en && !wr_en && !step_active) |=> $stable(pos)); // R10

endmodule

bind wiper_pos_ctrl wiper_pos_chk #(.POS_W(POS_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .recall_val (recall_val),
  .copy_en    (copy_en),
  .copy_val   (copy_val),
  .wr_en      (wr_en),
  .wr_val     (wr_val),
  .step_active(step_active),
  .pos        (pos),
  .tap_sel    (tap_sel)
);

// File: tb/wiper_pos_ctrl_tb_top.sv
`timescale 1ns/1ps
module wiper_pos_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  recall_val, copy_val, wr_val;
  logic        copy_en, wr_en, step_go, sel_n, sclk, sdat;
  logic [5:0]  pos;
  logic [63:0] tap_sel;

  int n_vec  = 0;
  int n_fail = 0;
  int expv;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  wiper_pos_ctrl dut_i (
    .clk(clk), .rst(rst), .recall_val(recall_val),
    .copy_en(copy_en), .copy_val(copy_val),
    .wr_en(wr_en), .wr_val(wr_val),
    .step_go(step_go), .sel_n(sel_n), .sclk(sclk), .sdat(sdat),
    .pos(pos), .tap_sel(tap_sel)
  );

  task automatic check_pos(input string req, input int expd);
    n_vec++;
    if (int'(pos) != expd) begin
      n_fail++;
      $display("FAIL %s pos actual=%0d expected=%0d", req, pos, expd);
    end
    n_vec++;
    if (tap_sel != (64'd1 << expd)) begin
      n_fail++;
      $display("FAIL %s tap_sel actual=%h expected=%h", req, tap_sel, 64'd1 << expd);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one serial clock pulse; complete before the task returns
  task automatic pulse(input logic up, input int hi_cycles);
    sdat = up;
    cyc(1);
    sclk = 1'b1;
    cyc(hi_cycles);
    sclk = 1'b0;
    cyc(3);
  endtask

  task automatic enter_step();
    sel_n = 1'b0;
    cyc(4);
    step_go = 1'b1;
    cyc(1);
    step_go = 1'b0;
  endtask

  initial begin
    rst = 1'b1; recall_val = 6'd37; copy_val = '0; wr_val = '0;
    copy_en = 1'b0; wr_en = 1'b0; step_go = 1'b0;
    sel_n = 1'b1; sclk = 1'b0; sdat = 1'b0;
    cyc(3);
    check_pos("R1 recall at reset", 37);
    rst = 1'b0;
    cyc(1);
    check_pos("R1 hold after reset", 37);

    // R10: pulses before step mode have no effect
    pulse(1'b1, 3);
    pulse(1'b0, 3);
    check_pos("R10 pulses outside step mode", 37);

    // R4/R2: write sweep over every position
    for (int v = 0; v < 64; v++) begin
      wr_val = 6'(v); wr_en = 1'b1;
      cyc(1);
      wr_en = 1'b0;
      check_pos("R4 R2 write sweep", v);
    end

    // R3/R5: copy sweep with a conflicting write
    for (int v = 0; v < 64; v++) begin
      copy_val = 6'(v); wr_val = ~6'(v); copy_en = 1'b1; wr_en = 1'b1;
      cyc(1);
      copy_en = 1'b0; wr_en = 1'b0;
      check_pos("R3 R5 copy over write", v);
    end

    // R7/R8: step up into the top rail
    wr_val = 6'd59; wr_en = 1'b1; cyc(1); wr_en = 1'b0;
    enter_step();
    expv = 59;
    for (int k = 0; k < 7; k++) begin
      pulse(1'b1, 3);
      expv = (expv == 63) ? 63 : expv + 1;
      check_pos("R7 R8 step up", expv);
    end
    // R7/R8: step down through 0
    for (int k = 0; k < 66; k++) begin
      pulse(1'b0, 3);
      expv = (expv == 0) ? 0 : expv - 1;
      check_pos("R7 R8 step down", expv);
    end
    // R7: a long pulse counts once
    pulse(1'b1, 12);
    check_pos("R7 long pulse single step", 1);

    // R6: copy collides with a detected step
    sdat = 1'b1;
    cyc(1);
    sclk = 1'b1;
    cyc(2);
    copy_val = 6'd10; copy_en = 1'b1;
    cyc(1);
    copy_en = 1'b0;
    check_pos("R6 copy replaces step", 10);
    sclk = 1'b0;
    cyc(4);
    check_pos("R6 dropped step not replayed", 10);

    // R6: write collides with a detected step
    sdat = 1'b0;
    cyc(1);
    sclk = 1'b1;
    cyc(2);
    wr_val = 6'd20; wr_en = 1'b1;
    cyc(1);
    wr_en = 1'b0;
    check_pos("R6 write replaces step", 20);
    sclk = 1'b0;
    cyc(4);
    check_pos("R6 dropped step not replayed", 20);

    // R9: still active after many pulses, then release select
    pulse(1'b1, 3);
    check_pos("R9 mode persists", 21);
    sel_n = 1'b1;
    cyc(5);
    pulse(1'b1, 3);
    pulse(1'b0, 3);
    check_pos("R9 pulses after release", 21);
    step_go = 1'b1; cyc(1); step_go = 1'b0;
    pulse(1'b1, 3);
    check_pos("R9 start ignored while deselected", 21);

    // R1: second reset with a new recall value clears step mode
    enter_step();
    recall_val = 6'd5; rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    check_pos("R1 second recall", 5);
    pulse(1'b1, 3);
    check_pos("R1 step mode cleared by reset", 5);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule